// File: doc/BRIEF.md
# Flash Command Sequencer

This block walks a byte-coded program held in a local memory and turns each instruction into register accesses on the software-mode port of a serial flash controller. It lets a host hand over a whole flash operation and step away until it ends. Such an operation might be a write enable, a page program with its address and data, and a wait for the flash to finish. The host only has to write the program and give one start pulse.

The program is a stream of variable-length instructions. Each one is an opcode byte followed by zero or more operand bytes. One instruction sends a string of bytes into the controller's transmit queue. Others wait for the transmit watermark, write an arbitrary controller register, or flip the transfer direction in the format register. One instruction runs a built-in polling loop that reads the flash status until its busy flag clears. That loop is bounded by a cycle limit supplied on a port. The engine ends on an exit opcode, on an opcode it does not know, or when the polling limit runs out. It reports which of these happened through a result code.

Both the program memory and the controller register port are read with a fixed latency of one cycle: data asked for in one cycle is taken in the next. Register writes complete in the cycle of the strobe.

Top module: `flash_cmd_seq`

## Requirements
- R1: Out of reset the engine is idle: `busy`, `done`, `err_code`, `reg_wr`, `reg_rd` and `prog_rd` are all 0, and no register strobe is issued while `busy` is 0.
- R2: A `start` pulse while idle begins execution at `start_addr`. A `start` pulse while `busy` is 1 is ignored: it neither moves execution nor changes the result.
- R3: Opcode 0x04 ends the program. `busy` falls, and `done` pulses for one cycle with `err_code` 0 (success), which is held until the next start.
- R4: Opcode 0x08 is followed by a count byte and then that many data bytes. Each data byte, in program order and zero-extended, is written to the transmit data register at offset 0x48. A count of 0 sends nothing, and execution resumes at the next byte.
- R5: Before every write to offset 0x48, the engine reads offset 0x48 until bit 31 (queue full) reads 0. No byte is written while the queue reports full.
- R6: Opcode 0x0C takes no operand and reads the pending register at offset 0x74 until bit 0 (transmit watermark) reads 1.
- R7: Opcode 0x10 is followed by an offset byte and a data byte. It writes the data byte, zero-extended, to that offset.
- R8: Opcode 0x18 is followed by one byte. The engine reads the format register at offset 0x40 and writes it back with only bit 3 replaced by bit 3 of that byte. All other bits of the register and of the operand are ignored.
- R9: Opcode 0x14 takes no operand. It sends 0x05 and discards the first received byte. It then repeatedly sends 0x00 and reads a byte back until bit 0 of that byte is 0. A received byte is read from offset 0x4C, where bit 31 = 1 means empty and the byte is retried.
- R10: Any other opcode ends execution with `err_code` 1, and no register access is made for it.
- R11: If opcode 0x14 is still polling once `poll_limit` cycles have passed since it began, execution ends with `err_code` 2, and the register port is released in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| start | input | 1 | One-cycle request to begin a program |
| start_addr | input | AW | Program memory address of the first opcode |
| poll_limit | input | TO_W | Cycle limit for one busy-wait instruction |
| prog_rd | output | 1 | Program memory read strobe |
| prog_addr | output | AW | Program memory read address |
| prog_rdata | input | 8 | Program byte, valid the cycle after `prog_rd` |
| reg_wr | output | 1 | Controller register write strobe |
| reg_rd | output | 1 | Controller register read strobe |
| reg_addr | output | RAW | Controller register byte offset |
| reg_wdata | output | RDW | Controller register write data |
| reg_rdata | input | RDW | Controller register read data, valid the cycle after `reg_rd` |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle pulse when execution ends |
| err_code | output | 2 | Result: 0 success, 1 unknown opcode, 2 poll timeout |

## Verification
The bench builds the engine with its defaults: an 8-bit program address (room for every program plus separate bases for two programs), a 32-bit register port, and the timeout counter generated with 16 bits. That last choice lets a run-time limit of 50 cycles cut a never-ending busy wait short within a few dozen cycles, while a limit of 1000 never fires on the short status sequences. A behavioural controller model with a queue that reports full for its first reads, a late watermark and a settable number of busy status replies makes every polling loop spin before it exits.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   // instruction opcodes
   localparam logic [7:0] OPC_END    = 8'h04;
   localparam logic [7:0] OPC_SEND   = 8'h08;
   localparam logic [7:0] OPC_WMWAIT = 8'h0C;
   localparam logic [7:0] OPC_REGWR  = 8'h10;
   localparam logic [7:0] OPC_BSYWT  = 8'h14;
   localparam logic [7:0] OPC_DIR    = 8'h18;

   typedef enum logic [1:0] {
      FAULT_NONE    = 2'd0,
      FAULT_BADOP   = 2'd1,
      FAULT_TIMEOUT = 2'd2
   } fault_e;

   typedef enum logic [4:0] {
      SQ_IDLE, SQ_FOP, SQ_DOP, SQ_FA1, SQ_DA1, SQ_FA2, SQ_DA2,
      SQ_FDAT, SQ_DDAT, SQ_TXCHK, SQ_TXPUT, SQ_WMWAIT, SQ_REGPUT,
      SQ_FMTGET, SQ_FMTPUT, SQ_BCHK, SQ_BPUT, SQ_BRX
   } seq_state_e;

   typedef enum logic [1:0] {
      PX_IDLE, PX_WRITE, PX_READ, PX_WAIT
   } port_state_e;

endpackage

// File: rtl/fcs_pc.sv
module fcs_pc #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] pc
);
   always_ff @(posedge clk) begin
      if (!rst_n)    pc <= '0;
      else if (load) pc <= load_val;
      else if (step) pc <= pc + AW'(1);
   end
endmodule

// File: rtl/fcs_wdog.sv
module fcs_wdog #(
   parameter int CW          = 16,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [CW-1:0] limit,
   output logic          expired
);
   generate
      if (USE_TIMEOUT) begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                cnt <= '0;
            else if (clr)              cnt <= '0;
            else if (en && !expired)   cnt <= cnt + CW'(1);
         end
         assign expired = en && (cnt >= limit);

         // R11: the count never runs past the limit while polling
         p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !clr && $stable(limit)) |-> (cnt <= limit));
      end else begin : g_none
         logic unused_wd;
         assign unused_wd = ^{clk, rst_n, clr, en, limit};
         assign expired   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fcs_regport.sv
module fcs_regport
   import fcs_pkg::*;
#(
   parameter int RAW = 8,
   parameter int RDW = 32,
   localparam int BW = $clog2(RDW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic           cmd_write,
   input  logic           cmd_poll,
   input  logic [RAW-1:0] cmd_addr,
   input  logic [RDW-1:0] cmd_wdata,
   input  logic [BW-1:0]  cmd_bit,
   input  logic           cmd_want,
   input  logic           abort,
   output logic           cmd_done,
   output logic [RDW-1:0] rd_data,
   output logic           reg_wr,
   output logic           reg_rd,
   output logic [RAW-1:0] reg_addr,
   output logic [RDW-1:0] reg_wdata,
   input  logic [RDW-1:0] reg_rdata
);
   port_state_e    st;
   logic           poll_q, want_q;
   logic [BW-1:0]  bit_q;
   logic           retry;

   assign retry    = poll_q && (reg_rdata[bit_q] != want_q);
   assign cmd_done = (st == PX_WRITE) || ((st == PX_WAIT) && !retry);
   assign rd_data  = reg_rdata;
   assign reg_wr   = (st == PX_WRITE);
   assign reg_rd   = (st == PX_READ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= PX_IDLE;
         reg_addr  <= '0;
         reg_wdata <= '0;
         poll_q    <= 1'b0;
         want_q    <= 1'b0;
         bit_q     <= '0;
      end else if (abort) begin
         st <= PX_IDLE;
      end else begin
         case (st)
            PX_IDLE: if (cmd_valid) begin
               reg_addr  <= cmd_addr;
               reg_wdata <= cmd_wdata;
               poll_q    <= cmd_poll && !cmd_write;
               want_q    <= cmd_want;
               bit_q     <= cmd_bit;
               st        <= cmd_write ? PX_WRITE : PX_READ;
            end
            PX_WRITE: st <= PX_IDLE;
            PX_READ:  st <= PX_WAIT;
            PX_WAIT:  st <= retry ? PX_READ : PX_IDLE;
            default:  st <= PX_IDLE;
         endcase
      end
   end

   // R11: an abort releases the register port on the next cycle
   p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!reg_wr && !reg_rd));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int          AW          = 8,
   parameter int          RAW         = 8,
   parameter int          RDW         = 32,
   parameter int          TO_W        = 16,
   parameter bit          USE_TIMEOUT = 1'b1,
   parameter logic [7:0]  TXD_OFS     = 8'h48,
   parameter logic [7:0]  RXD_OFS     = 8'h4C,
   parameter logic [7:0]  PEND_OFS    = 8'h74,
   parameter logic [7:0]  FMT_OFS     = 8'h40,
   parameter logic [7:0]  STATUS_CMD  = 8'h05,
   parameter int          WM_BIT      = 0,
   parameter int          DIR_BIT     = 3,
   parameter int          BUSY_BIT    = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   start_addr,
   input  logic [TO_W-1:0] poll_limit,
   output logic            prog_rd,
   output logic [AW-1:0]   prog_addr,
   input  logic [7:0]      prog_rdata,
   output logic            reg_wr,
   output logic            reg_rd,
   output logic [RAW-1:0]  reg_addr,
   output logic [RDW-1:0]  reg_wdata,
   input  logic [RDW-1:0]  reg_rdata,
   output logic            busy,
   output logic            done,
   output logic [1:0]      err_code
);
   localparam int BW       = $clog2(RDW);
   localparam int FULL_BIT = RDW - 1;

   generate
      if (AW < 2 || AW > 32) begin : g_bad_aw
         $error("flash_cmd_seq: AW out of range");
      end
      if (RDW < 9 || RAW < 8) begin : g_bad_port
         $error("flash_cmd_seq: register port too narrow");
      end
      if (DIR_BIT > 7 || BUSY_BIT > 7 || WM_BIT >= RDW) begin : g_bad_bits
         $error("flash_cmd_seq: bit position out of range");
      end
   endgenerate

   seq_state_e     st;
   logic [7:0]     op_q, arg_q, dat_q, cnt_q;
   logic [RDW-1:0] fmt_q, fmt_new;
   logic           first_q, done_q;
   fault_e         err_q;

   logic           c_valid, c_write, c_poll, c_want, c_done;
   logic [RAW-1:0] c_addr;
   logic [RDW-1:0] c_wdata, rd_data;
   logic [BW-1:0]  c_bit;
   logic           wd_en, wd_clr, to_hit, pc_load;

   assign busy     = (st != SQ_IDLE);
   assign done     = done_q;
   assign err_code = err_q;
   assign prog_rd  = (st == SQ_FOP) || (st == SQ_FA1) || (st == SQ_FA2) || (st == SQ_FDAT);
   assign pc_load  = (st == SQ_IDLE) && start;
   assign wd_en    = (st == SQ_BCHK) || (st == SQ_BPUT) || (st == SQ_BRX);
   assign wd_clr   = (st == SQ_DOP) && (prog_rdata == OPC_BSYWT);
   assign fmt_new  = (fmt_q & ~(RDW'(1) << DIR_BIT)) | (RDW'(arg_q[DIR_BIT]) << DIR_BIT);

   fcs_pc #(.AW(AW)) u_pc (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .load_val(start_addr),
      .step(prog_rd), .pc(prog_addr)
   );

   fcs_wdog #(.CW(TO_W), .USE_TIMEOUT(USE_TIMEOUT)) u_wdog (
      .clk(clk), .rst_n(rst_n), .clr(wd_clr), .en(wd_en),
      .limit(poll_limit), .expired(to_hit)
   );

   fcs_regport #(.RAW(RAW), .RDW(RDW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(c_valid), .cmd_write(c_write), .cmd_poll(c_poll),
      .cmd_addr(c_addr), .cmd_wdata(c_wdata), .cmd_bit(c_bit), .cmd_want(c_want),
      .abort(to_hit), .cmd_done(c_done), .rd_data(rd_data),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   // register access wanted by the current state
   always_comb begin
      c_valid = 1'b1;
      c_write = 1'b0;
      c_poll  = 1'b0;
      c_addr  = RAW'(TXD_OFS);
      c_wdata = '0;
      c_bit   = BW'(FULL_BIT);
      c_want  = 1'b0;
      case (st)
         SQ_TXCHK, SQ_BCHK: c_poll = 1'b1;
         SQ_TXPUT: begin
            c_write = 1'b1;
            c_wdata = RDW'(dat_q);
         end
         SQ_BPUT: begin
            c_write = 1'b1;
            c_wdata = first_q ? RDW'(STATUS_CMD) : '0;
         end
         SQ_BRX: begin
            c_addr = RAW'(RXD_OFS);
            c_poll = 1'b1;
         end
         SQ_WMWAIT: begin
            c_addr = RAW'(PEND_OFS);
            c_poll = 1'b1;
            c_bit  = BW'(WM_BIT);
            c_want = 1'b1;
         end
         SQ_REGPUT: begin
            c_write = 1'b1;
            c_addr  = RAW'(arg_q);
            c_wdata = RDW'(dat_q);
         end
         SQ_FMTGET: c_addr = RAW'(FMT_OFS);
         SQ_FMTPUT: begin
            c_write = 1'b1;
            c_addr  = RAW'(FMT_OFS);
            c_wdata = fmt_new;
         end
         default: c_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         op_q    <= '0;
         arg_q   <= '0;
         dat_q   <= '0;
         cnt_q   <= '0;
         fmt_q   <= '0;
         first_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= FAULT_NONE;
      end else begin
         done_q <= 1'b0;
         if (to_hit) begin
            st     <= SQ_IDLE;
            err_q  <= FAULT_TIMEOUT;
            done_q <= 1'b1;
         end else begin
            case (st)
               SQ_IDLE: if (start) begin
                  st    <= SQ_FOP;
                  err_q <= FAULT_NONE;
               end
               SQ_FOP: st <= SQ_DOP;
               SQ_DOP: begin
                  op_q <= prog_rdata;
                  case (prog_rdata)
                     OPC_END: begin
                        st     <= SQ_IDLE;
                        done_q <= 1'b1;
                     end
                     OPC_SEND, OPC_REGWR, OPC_DIR: st <= SQ_FA1;
                     OPC_WMWAIT: st <= SQ_WMWAIT;
                     OPC_BSYWT: begin
                        first_q <= 1'b1;
                        st      <= SQ_BCHK;
                     end
                     default: begin
                        st     <= SQ_IDLE;
                        err_q  <= FAULT_BADOP;
                        done_q <= 1'b1;
                     end
                  endcase
               end
               SQ_FA1: st <= SQ_DA1;
               SQ_DA1: begin
                  arg_q <= prog_rdata;
                  cnt_q <= prog_rdata;
                  if (op_q == OPC_SEND)       st <= (prog_rdata == 8'd0) ? SQ_FOP : SQ_FDAT;
                  else if (op_q == OPC_REGWR) st <= SQ_FA2;
                  else                        st <= SQ_FMTGET;
               end
               SQ_FA2: st <= SQ_DA2;
               SQ_DA2: begin
                  dat_q <= prog_rdata;
                  st    <= SQ_REGPUT;
               end
               SQ_FDAT: st <= SQ_DDAT;
               SQ_DDAT: begin
                  dat_q <= prog_rdata;
                  st    <= SQ_TXCHK;
               end
               SQ_TXCHK: if (c_done) st <= SQ_TXPUT;
               SQ_TXPUT: if (c_done) begin
                  cnt_q <= cnt_q - 8'd1;
                  st    <= (cnt_q == 8'd1) ? SQ_FOP : SQ_FDAT;
               end
               SQ_WMWAIT, SQ_REGPUT, SQ_FMTPUT: if (c_done) st <= SQ_FOP;
               SQ_FMTGET: if (c_done) begin
                  fmt_q <= rd_data;
                  st    <= SQ_FMTPUT;
               end
               SQ_BCHK: if (c_done) st <= SQ_BPUT;
               SQ_BPUT: if (c_done) st <= SQ_BRX;
               SQ_BRX: if (c_done) begin
                  if (first_q) begin
                     first_q <= 1'b0;
                     st      <= SQ_BCHK;
                  end else begin
                     st <= rd_data[BUSY_BIT] ? SQ_BCHK : SQ_FOP;
                  end
               end
               default: st <= SQ_IDLE;
            endcase
         end
      end
   end

   // R1: no register strobe while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_wr && !reg_rd));
   // R3: completion is reported only once idle, for exactly one cycle
   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: a push to the transmit register carries only a byte
   p_push_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RAW'(TXD_OFS)) |-> (reg_wdata[RDW-1:8] == '0));
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [127:0] prog;
      logic [15:0]  busy_n;
      logic [1:0]   err;
      logic [7:0]   ntx;
      logic [7:0]   nip;
      logic [127:0] tx;
   } case_t;

   // program and expected transmit bytes are written first byte leftmost
   localparam case_t CASES [8] = '{
      '{128'h08031122_33040000_00000000_00000000, 16'd0, 2'd0, 8'd3, 8'd0,
        128'h112233_00_00000000_00000000_00000000},
      '{128'h0801060C_04000000_00000000_00000000, 16'd0, 2'd0, 8'd1, 8'd4,
        128'h06000000_00000000_00000000_00000000},
      '{128'h18001404_00000000_00000000_00000000, 16'd2, 2'd0, 8'd4, 8'd0,
        128'h05000000_00000000_00000000_00000000},
      '{128'h18001404_00000000_00000000_00000000, 16'd0, 2'd0, 8'd2, 8'd0,
        128'h05000000_00000000_00000000_00000000},
      '{128'h07040000_00000000_00000000_00000000, 16'd0, 2'd1, 8'd0, 8'd0,
        128'h0},
      '{128'h08000801_5A040000_00000000_00000000, 16'd0, 2'd0, 8'd1, 8'd0,
        128'h5A000000_00000000_00000000_00000000},
      '{128'h0802A53C_18001418_08080177_04000000, 16'd1, 2'd0, 8'd6, 8'd0,
        128'hA53C0500_00770000_00000000_00000000},
      '{128'h0C040000_00000000_00000000_00000000, 16'd0, 2'd0, 8'd0, 8'd4,
        128'h0}
   };

   localparam logic [7:0] PAGE_SEQ [33] = '{
      8'h08, 8'h01, 8'h06, 8'h0C, 8'h10, 8'h18, 8'h02,
      8'h08, 8'h04, 8'h02, 8'h01, 8'h00, 8'h00,
      8'h08, 8'h02, 8'hDE, 8'hAD, 8'h0C, 8'h10, 8'h18, 8'h00,
      8'h18, 8'h00, 8'h10, 8'h18, 8'h02, 8'h14, 8'h10, 8'h18, 8'h00,
      8'h18, 8'h08, 8'h04
   };
   localparam logic [7:0] PAGE_TX [9] = '{
      8'h06, 8'h02, 8'h01, 8'h00, 8'h00, 8'hDE, 8'hAD, 8'h05, 8'h00
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  start_addr = '0;
   logic [15:0] poll_limit = 16'd1000;
   logic        prog_rd, reg_wr, reg_rd, busy, done;
   logic [7:0]  prog_addr, reg_addr;
   logic [7:0]  prog_rdata = '0;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata = '0;
   logic [1:0]  err_code;

   int nchk = 0, nfail = 0;

   // controller model state
   logic [7:0]  pmem [256];
   logic [7:0]  txlog [64];
   logic [7:0]  rxbuf [64];
   logic [7:0]  wl_addr [16];
   logic [31:0] wl_data [16];
   logic [31:0] fmt_reg;
   int ntx, nw, rx_wr, rx_rd, nrd_tx, nrd_ip;
   int txfull_left, busy_left, wm_left;
   bit bad_push;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .poll_limit(poll_limit), .prog_rd(prog_rd), .prog_addr(prog_addr),
      .prog_rdata(prog_rdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy(busy), .done(done), .err_code(err_code)
   );

   always @(posedge clk) begin
      if (prog_rd) prog_rdata <= pmem[prog_addr];
      if (reg_wr) begin
         if (reg_addr == 8'h48) begin
            if (txfull_left > 0) bad_push = 1'b1;
            txlog[ntx & 63] = reg_wdata[7:0];
            ntx = ntx + 1;
            if (!fmt_reg[3]) begin
               if (reg_wdata[7:0] == 8'h05) rxbuf[rx_wr & 63] = 8'hFF;
               else if (busy_left > 0) begin
                  rxbuf[rx_wr & 63] = 8'h03;
                  busy_left = busy_left - 1;
               end else rxbuf[rx_wr & 63] = 8'h00;
               rx_wr = rx_wr + 1;
            end
         end else if (reg_addr == 8'h40) begin
            fmt_reg = reg_wdata;
         end else begin
            wl_addr[nw & 15] = reg_addr;
            wl_data[nw & 15] = reg_wdata;
            nw = nw + 1;
         end
      end
      if (reg_rd) begin
         case (reg_addr)
            8'h48: begin
               nrd_tx = nrd_tx + 1;
               if (txfull_left > 0) begin
                  reg_rdata <= 32'h8000_0000;
                  txfull_left = txfull_left - 1;
               end else reg_rdata <= 32'h0;
            end
            8'h4C: begin
               if (rx_rd < rx_wr) begin
                  reg_rdata <= {24'h0, rxbuf[rx_rd & 63]};
                  rx_rd = rx_rd + 1;
               end else reg_rdata <= 32'h8000_0000;
            end
            8'h74: begin
               nrd_ip = nrd_ip + 1;
               if (wm_left > 0) begin
                  reg_rdata <= 32'h0;
                  wm_left = wm_left - 1;
               end else reg_rdata <= 32'h1;
            end
            8'h40:   reg_rdata <= fmt_reg;
            default: reg_rdata <= 32'hDEAD_BEEF;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset(input int busy_n, input logic [31:0] fmt0);
      ntx = 0; nw = 0; rx_wr = 0; rx_rd = 0; nrd_tx = 0; nrd_ip = 0;
      txfull_left = 2; busy_left = busy_n; wm_left = 3; bad_push = 1'b0;
      fmt_reg = fmt0;
      for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
   endtask

   task automatic pulse_start(input logic [7:0] base);
      @(negedge clk);
      start = 1'b1;
      start_addr = base;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string tag, output int cyc);
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) chk(tag, 32'h0, 32'h1);
   endtask

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy/done/err after reset", {29'h0, busy, done, err_code != 2'd0}, 32'h0);
      chk("R1 strobes after reset", {29'h0, reg_wr, reg_rd, prog_rd}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", {31'h0, busy}, 32'h0);

      // table walk
      for (int k = 0; k < 8; k++) begin
         model_reset(int'(CASES[k].busy_n), 32'h0008_000D);
         for (int i = 0; i < 16; i++) pmem[i] = CASES[k].prog[127-8*i -: 8];
         poll_limit = 16'd1000;
         pulse_start(8'h00);
         wait_done($sformatf("R3 done case %0d", k), cyc);
         chk($sformatf("R3/R10 err case %0d", k), {30'h0, err_code}, {30'h0, CASES[k].err});
         chk($sformatf("R4 tx count case %0d", k), ntx, {24'h0, CASES[k].ntx});
         for (int i = 0; i < int'(CASES[k].ntx); i++)
            chk($sformatf("R4/R9 tx byte %0d case %0d", i, k), {24'h0, txlog[i]},
                {24'h0, CASES[k].tx[127-8*i -: 8]});
         chk($sformatf("R5 tx polls case %0d", k), nrd_tx,
             (CASES[k].ntx == 0) ? 32'd0 : 32'(CASES[k].ntx) + 32'd2);
         chk($sformatf("R5 no push while full case %0d", k), {31'h0, bad_push}, 32'h0);
         chk($sformatf("R6 watermark polls case %0d", k), nrd_ip, {24'h0, CASES[k].nip});
         @(negedge clk);
         chk($sformatf("R3 idle after case %0d", k), {31'h0, busy}, 32'h0);
      end

      // typical page program flow, R7 and R8 together
      model_reset(0, 32'h0008_000D);
      for (int i = 0; i < 33; i++) pmem[i] = PAGE_SEQ[i];
      pulse_start(8'h00);
      wait_done("R3 page flow done", cyc);
      chk("R3 page flow err", {30'h0, err_code}, 32'h0);
      chk("R4 page flow tx count", ntx, 32'd9);
      for (int i = 0; i < 9; i++)
         chk($sformatf("R9 page flow tx %0d", i), {24'h0, txlog[i]}, {24'h0, PAGE_TX[i]});
      chk("R7 page flow reg writes", nw, 32'd4);
      for (int i = 0; i < 4; i++) begin
         chk($sformatf("R7 write %0d offset", i), {24'h0, wl_addr[i]}, 32'h18);
         chk($sformatf("R7 write %0d data", i), wl_data[i], (i % 2 == 0) ? 32'h2 : 32'h0);
      end
      chk("R8 format after flow", fmt_reg, 32'h0008_000D);
      chk("R6 page flow watermark polls", nrd_ip, 32'd5);

      // R8: only bit 3 of the operand reaches only bit 3 of the register
      model_reset(0, 32'h0008_000D);
      pmem[0] = 8'h18; pmem[1] = 8'hF7; pmem[2] = 8'h04;
      pulse_start(8'h00);
      wait_done("R8 clear done", cyc);
      chk("R8 clear direction", fmt_reg, 32'h0008_0005);
      model_reset(0, 32'h0);
      pmem[0] = 8'h18; pmem[1] = 8'h08; pmem[2] = 8'h04;
      pulse_start(8'h00);
      wait_done("R8 set done", cyc);
      chk("R8 set direction", fmt_reg, 32'h0000_0008);

      // R7 zero extension of a high data byte
      model_reset(0, 32'h0008_000D);
      pmem[0] = 8'h10; pmem[1] = 8'h60; pmem[2] = 8'hC3; pmem[3] = 8'h04;
      pulse_start(8'h00);
      wait_done("R7 done", cyc);
      chk("R7 offset", {24'h0, wl_addr[0]}, 32'h60);
      chk("R7 data", wl_data[0], 32'h0000_00C3);

      // R2: second start while busy is ignored, base address honoured
      model_reset(5, 32'h0008_000D);
      pmem[8'h40] = 8'h18; pmem[8'h41] = 8'h00; pmem[8'h42] = 8'h14; pmem[8'h43] = 8'h04;
      pmem[8'h80] = 8'h07;
      pulse_start(8'h40);
      repeat (4) @(negedge clk);
      start = 1'b1;
      start_addr = 8'h80;
      @(negedge clk);
      start = 1'b0;
      wait_done("R2 done", cyc);
      chk("R2 result unchanged by late start", {30'h0, err_code}, 32'h0);
      chk("R2 tx count from first program", ntx, 32'd7);

      // R11: endless busy status with a short limit
      model_reset(1000, 32'h0008_000D);
      pmem[0] = 8'h18; pmem[1] = 8'h00; pmem[2] = 8'h14; pmem[3] = 8'h04;
      poll_limit = 16'd50;
      pulse_start(8'h00);
      wait_done("R11 done", cyc);
      chk("R11 timeout code", {30'h0, err_code}, 32'h2);
      chk("R11 not before the limit", {31'h0, cyc >= 50}, 32'h1);
      chk("R11 soon after the limit", {31'h0, cyc <= 80}, 32'h1);
      @(negedge clk);
      chk("R11 port released", {30'h0, reg_wr, reg_rd}, 32'h0);
      chk("R11 error held", {30'h0, err_code}, 32'h2);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule